// File: doc/BRIEF.md
# Keyed Write-Lock Sequencer for Segmented Flash

This block sits in front of the page-load logic of a flash array built from several segments. Each segment keeps its own lock flag. A short keyed command of three writes sets the lock and opens a load window for the page write that follows. A longer keyed command of six writes clears the lock. When a segment is locked, any write that is not part of a page load opened by the key is dropped.

Each write arrives as a one-cycle strobe. It carries a segment index that has already been decoded upstream, plus an address and a data byte local to that segment. The block returns two things. The first is the lock flag of every segment. The second is a registered per-segment permit pulse, which tells the page-load logic to take the write. Command writes are always consumed and are never forwarded. A write that breaks a partly entered key returns that segment's tracker to idle, and the lock flag stays as it was.

Top module: `wpg_lock_top`

## Requirements
- R1: After a synchronous reset every lock flag is 0 and every permit bit is 0.
- R2: A write to an unlocked segment that is not a key step raises bit s of `wr_permit` in the cycle after the strobe, where s is `wr_seg`.
- R3: The key writes AA to 5555, then 55 to 2AAA, then A0 to 5555 (hex, segment-local) set bit s of `lock_on`. None of the three key writes is permitted.
- R4: After the lock key completes, the next PAGE_BYTES writes to that segment are permitted whatever their address or data, including key-like values. The write after those is dropped.
- R5: The load window closes after LOAD_GAP consecutive cycles with no strobe to that segment. A write within the window restarts this count.
- R6: A write to a locked segment outside a load window is dropped, and the lock flag stays set.
- R7: The key writes AA to 5555, 55 to 2AAA, 80 to 5555, AA to 5555, 55 to 2AAA, 20 to 5555 clear the lock flag, and none of them is permitted. Later plain writes are then permitted.
- R8: A write that does not match the expected next key step returns the tracker to idle. The lock flag does not change, and the write is treated as an ordinary write (permitted if unlocked, dropped if locked). The one exception is AA to 5555, which restarts the key at step one.
- R9: Lock state and key progress are kept per segment. Key steps interleaved across segments complete independently, and they do not touch other segments' lock flags.
- R10: At most one bit of `wr_permit` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_seg | input | SEG_W | Target segment index |
| wr_addr | input | ADDR_W | Segment-local write address |
| wr_data | input | 8 | Write data byte |
| lock_on | output | 2**SEG_W | Lock flag per segment |
| wr_permit | output | 2**SEG_W | Registered permit pulse per segment |

## Verification
The bench breaks keys at several depths. This includes a break in the unlock key right after its 80 step, where a design that restarts wrongly would clear the lock anyway. It also checks a repeated AA that must restart the key rather than abort it. It fills a whole page, with key-like bytes inside the window, and then sends one more write. A design that decodes keys inside the window, or miscounts by one, would leak or drop a byte. It also interleaves keys on two segments, which catches any tracker state shared between segments. Finally, it lets the window time out, so that a design ignoring the gap would keep forwarding writes to a locked segment.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_LOCK   = 8'hA0;
  localparam logic [7:0] KEY_ERASE  = 8'h80;
  localparam logic [7:0] KEY_UNLOCK = 8'h20;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_FIRST, CMD_SECOND, CMD_LOCK, CMD_ERASE, CMD_UNLOCK
  } cmd_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_U3, ST_U4, ST_U5
  } seq_t;
endpackage

// File: rtl/wpg_cmd_decode.sv
module wpg_cmd_decode
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output cmd_t              cmd_o
);
  logic at_hi, at_lo;
  assign at_hi = (addr_i == ADDR_HI);
  assign at_lo = (addr_i == ADDR_LO);

  always_comb begin
    cmd_o = CMD_NONE;
    if (at_hi) begin
      case (data_i)
        KEY_FIRST:  cmd_o = CMD_FIRST;
        KEY_LOCK:   cmd_o = CMD_LOCK;
        KEY_ERASE:  cmd_o = CMD_ERASE;
        KEY_UNLOCK: cmd_o = CMD_UNLOCK;
        default:    cmd_o = CMD_NONE;
      endcase
    end else if (at_lo && data_i == KEY_SECOND) begin
      cmd_o = CMD_SECOND;
    end
  end
endmodule

// File: rtl/wpg_seg_fsm.sv
module wpg_seg_fsm
  import wpg_pkg::*;
#(
  parameter int PAGE_BYTES = 256,
  parameter int LOAD_GAP   = 150
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_i,
  input  cmd_t cmd_i,
  output logic lock_o,
  output logic permit_o
);
  localparam int CNT_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int GAP_W = (LOAD_GAP > 1) ? $clog2(LOAD_GAP) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAGE_BYTES - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(LOAD_GAP - 1);

  seq_t st_q, st_d;
  logic lock_q, lock_d, win_q, win_d, permit_q, fwd, hit;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  always_comb begin
    st_d   = st_q;
    lock_d = lock_q;
    win_d  = win_q;
    cnt_d  = cnt_q;
    gap_d  = gap_q;
    hit    = 1'b0;
    fwd    = 1'b0;
    if (stb_i) begin
      gap_d = '0;
      if (win_q) begin
        fwd   = 1'b1;
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) win_d = 1'b0;
      end else begin
        hit  = (cmd_i == CMD_FIRST);
        st_d = hit ? ST_K1 : ST_IDLE;
        case (st_q)
          ST_K1: if (cmd_i == CMD_SECOND) begin st_d = ST_K2; hit = 1'b1; end
          ST_K2: begin
            if (cmd_i == CMD_LOCK) begin
              st_d = ST_IDLE; hit = 1'b1; lock_d = 1'b1;
              win_d = 1'b1; cnt_d = '0;
            end else if (cmd_i == CMD_ERASE) begin
              st_d = ST_U3; hit = 1'b1;
            end
          end
          ST_U3: if (cmd_i == CMD_FIRST) st_d = ST_U4;
          ST_U4: if (cmd_i == CMD_SECOND) begin st_d = ST_U5; hit = 1'b1; end
          ST_U5: if (cmd_i == CMD_UNLOCK) begin
            st_d = ST_IDLE; hit = 1'b1; lock_d = 1'b0;
          end
          default: ;
        endcase
        fwd = !hit && !lock_q;
      end
    end else if (win_q) begin
      gap_d = gap_q + 1'b1;
      if (gap_q == GAP_LAST) begin
        win_d = 1'b0;
        gap_d = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      lock_q   <= 1'b0;
      win_q    <= 1'b0;
      cnt_q    <= '0;
      gap_q    <= '0;
      permit_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      lock_q   <= lock_d;
      win_q    <= win_d;
      cnt_q    <= cnt_d;
      gap_q    <= gap_d;
      permit_q <= fwd;
    end
  end

  assign lock_o   = lock_q;
  assign permit_o = permit_q;

  // R3: lock rises only from the last lock-key state
  p_lock_from_key_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_q) |-> $past(st_q == ST_K2));
  // R7: lock falls only from the last unlock-key state
  p_unlock_from_key_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_q) |-> $past(st_q == ST_U5));
  // R6: a permit while locked needs an open window
  p_locked_drop_r6: assert property (@(posedge clk) disable iff (rst)
    permit_q |-> $past(stb_i) && ($past(!lock_q) || $past(win_q)));
  // R5: window closes only on a strobe (page full) or an expired gap
  p_win_close_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(win_q) |-> ($past(stb_i) || $past(gap_q == GAP_LAST)));
  // R8: lock flag never moves without a strobe
  p_lock_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !stb_i |=> $stable(lock_q));
endmodule

// File: rtl/wpg_lock_top.sv
module wpg_lock_top
  import wpg_pkg::*;
#(
  parameter int SEG_W      = 3,
  parameter int ADDR_W     = 15,
  parameter int PAGE_BYTES = 256,
  parameter int LOAD_GAP   = 150,
  parameter logic [ADDR_W-1:0] ADDR_HI = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_LO = 15'h2AAA,
  localparam int NUM_SEG   = 1 << SEG_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [SEG_W-1:0]   wr_seg,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         wr_data,
  output logic [NUM_SEG-1:0] lock_on,
  output logic [NUM_SEG-1:0] wr_permit
);
  cmd_t cmd;

  wpg_cmd_decode #(.ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI), .ADDR_LO(ADDR_LO)) u_dec (
    .addr_i(wr_addr),
    .data_i(wr_data),
    .cmd_o (cmd)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    logic sel;
    assign sel = wr_stb && (wr_seg == SEG_W'(s));
    wpg_seg_fsm #(.PAGE_BYTES(PAGE_BYTES), .LOAD_GAP(LOAD_GAP)) u_fsm (
      .clk     (clk),
      .rst     (rst),
      .stb_i   (sel),
      .cmd_i   (cmd),
      .lock_o  (lock_on[s]),
      .permit_o(wr_permit[s])
    );
  end

  // R10: one write per cycle, so at most one permit
  p_permit_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_permit));
  // R9: a segment's lock moves only when it was addressed
  p_lock_isolated_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(lock_on));
endmodule

// File: tb/wpg_lock_top_tb.sv
module wpg_lock_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SEG_W = 3;
  localparam int NSEG = 1 << SEG_W;
  localparam int PAGE = 256;
  localparam int GAP = 150;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [SEG_W-1:0] wr_seg = '0;
  logic [14:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [NSEG-1:0] lock_on, wr_permit;
  logic [NSEG-1:0] got;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpg_lock_top dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_seg(wr_seg),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .lock_on(lock_on), .wr_permit(wr_permit)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int seg, input logic [14:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_seg = SEG_W'(seg); wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
    got = wr_permit;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lock_key(input int seg, input string req);
    wr(seg, 15'h5555, 8'hAA); chk(req, got, '0);
    wr(seg, 15'h2AAA, 8'h55); chk(req, got, '0);
    wr(seg, 15'h5555, 8'hA0); chk(req, got, '0);
  endtask

  task automatic t_reset;
    chk("R1 lock", lock_on, '0);
    chk("R1 permit", wr_permit, '0);
  endtask

  task automatic t_plain;
    wr(2, 15'h0100, 8'h33);
    chk("R2 plain permit", got, 8'h04);
    chk("R10 single bit", $countones(got), 1);
  endtask

  task automatic t_lock_and_page;
    int bad = 0;
    lock_key(1, "R3 key consumed");
    chk("R3 lock set", lock_on, 8'h02);
    for (int i = 0; i < PAGE; i++) begin
      wr(1, (i % 3 == 0) ? 15'h5555 : 15'(i), (i % 2 == 0) ? 8'hAA : 8'(i));
      if (got !== 8'h02) bad++;
    end
    chk("R4 full page permitted", bad, 0);
    wr(1, 15'h0007, 8'h11);
    chk("R4 write past page dropped", got, '0);
    chk("R6 lock kept", lock_on, 8'h02);
  endtask

  task automatic t_locked_drop;
    wr(1, 15'h0040, 8'h5A);
    chk("R6 locked drop", got, '0);
    chk("R6 lock kept", lock_on, 8'h02);
  endtask

  task automatic t_gap;
    lock_key(1, "R3 key consumed");
    wr(1, 15'h0001, 8'h01); chk("R5 first load", got, 8'h02);
    idle(100);
    wr(1, 15'h0002, 8'h02); chk("R5 within gap", got, 8'h02);
    idle(GAP + 10);
    wr(1, 15'h0003, 8'h03); chk("R5 after gap dropped", got, '0);
  endtask

  task automatic t_abort;
    wr(1, 15'h5555, 8'hAA);
    wr(1, 15'h2AAA, 8'h55);
    wr(1, 15'h5555, 8'h33); chk("R8 mismatch dropped while locked", got, '0);
    wr(1, 15'h2AAA, 8'h55); chk("R8 tracker idle", got, '0);
    wr(1, 15'h0010, 8'h10); chk("R8 no window opened", got, '0);
    chk("R8 lock unchanged", lock_on, 8'h02);
    wr(1, 15'h5555, 8'hAA);
    wr(1, 15'h5555, 8'hAA);
    wr(1, 15'h2AAA, 8'h55);
    wr(1, 15'h5555, 8'hA0);
    wr(1, 15'h0011, 8'h11); chk("R8 AA restart completes key", got, 8'h02);
    idle(GAP + 10);
    wr(3, 15'h5555, 8'hAA); chk("R8 unlocked key step consumed", got, '0);
    wr(3, 15'h0100, 8'h12); chk("R8 unlocked mismatch forwarded", got, 8'h08);
    chk("R8 unlocked lock unchanged", lock_on, 8'h02);
  endtask

  task automatic t_unlock;
    wr(1, 15'h5555, 8'hAA); chk("R7 step", got, '0);
    wr(1, 15'h2AAA, 8'h55); chk("R7 step", got, '0);
    wr(1, 15'h5555, 8'h80); chk("R7 step", got, '0);
    wr(1, 15'h5555, 8'hAA); chk("R7 step", got, '0);
    wr(1, 15'h2AAA, 8'h55); chk("R7 step", got, '0);
    chk("R7 lock held before last step", lock_on, 8'h02);
    wr(1, 15'h5555, 8'h20); chk("R7 step", got, '0);
    chk("R7 lock cleared", lock_on, '0);
    wr(1, 15'h0200, 8'h77); chk("R7 plain permitted", got, 8'h02);
  endtask

  task automatic t_interleave;
    wr(4, 15'h5555, 8'hAA);
    wr(5, 15'h5555, 8'hAA);
    wr(4, 15'h2AAA, 8'h55);
    wr(5, 15'h2AAA, 8'h55);
    wr(4, 15'h5555, 8'hA0);
    chk("R9 only segment 4 locked", lock_on, 8'h10);
    wr(5, 15'h5555, 8'hA0);
    chk("R9 both locked", lock_on, 8'h30);
    idle(GAP + 10);
    wr(4, 15'h5555, 8'hAA);
    wr(4, 15'h2AAA, 8'h55);
    wr(4, 15'h5555, 8'h80);
    wr(4, 15'h2AAA, 8'h55); chk("R8 break after 80 dropped", got, '0);
    wr(4, 15'h2AAA, 8'h55);
    wr(4, 15'h5555, 8'h20);
    chk("R8 broken unlock keeps lock", lock_on, 8'h30);
    wr(6, 15'h0300, 8'h01);
    chk("R9 other segment free", got, 8'h40);
    chk("R10 single bit", $countones(got), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst = 1'b0;
    idle(1);
    t_reset();
    t_plain();
    t_lock_and_page();
    t_locked_drop();
    t_gap();
    t_abort();
    t_unlock();
    t_interleave();
    idle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule